// File: doc/BRIEF.md
# DRAM Cycle Decoder with Latched Parallel Test Mode

This block sits on the device side of a dynamic memory and observes the four asynchronous active-low control strobes: row strobe, column strobe, write enable and output enable. It samples them through a synchronizer on a fast internal clock. From the order in which the strobes change, it classifies every row-strobe cycle as one of these: a normal read, an early write, a read-modify-write, a write whose timing is indeterminate, a row-only refresh, a column-before-row refresh, or a test-mode entry. When the row strobe returns high, the block reports the classification as a 3-bit code together with a one-clock valid pulse.

A test-mode flag is set by a column-before-row cycle that has write enable held low. The flag stays set until a refresh cycle clears it. While the flag is set, each data lane does not carry the plain read bit. Instead it carries a pass/fail result that compares a group of internal bits, one for each combination of the two ignored low column bits. Test-mode reads also turn the output on later than normal reads do. The memory array is outside the block: a model in the bench supplies the read bits and the compare groups.

The block also produces the output-enable control for the data pins. The output is driven only during a read-type cycle, and only while both the column strobe and output enable are low.

Top module: `dram_cycle_decoder`

## Requirements
- R1: A row-strobe fall seen while the column strobe is already low and write enable is high is a column-before-row refresh; its code is 5.
- R2: The same ordering with write enable also low is a test-mode entry; its code is 6, and `test_mode` reads 1 from then on.
- R3: `test_mode` stays 1 through read and write cycles. A row-only refresh or a column-before-row refresh returns it to 0.
- R4: A row-strobe cycle in which the column strobe never falls is a row-only refresh; its code is 4.
- R5: If write enable is low when the column strobe falls, the cycle is an early write with code 2, and `dq_oe` stays 0 for the whole cycle even when output enable is low.
- R6: A cycle in which the column strobe falls with write enable high is a read with code 1. `dq_oe` is 1 only while the column strobe and output enable are both low, and it drops when either one rises. In normal mode `dq_o` equals `rd_data`.
- R7: In a read, if write enable falls at least RMW_MIN sampled clocks after the column strobe fell, the cycle becomes a read-modify-write with code 3. Read data is driven before write enable falls.
- R8: If write enable falls after the column strobe but fewer than RMW_MIN sampled clocks after it, the code is 7 (indeterminate) and the output is switched off for the rest of the cycle.
- R9: In test mode, lane i of `dq_o` is 1 exactly when the bits `cmp_bits[i*GRP +: GRP]` are all equal, and 0 otherwise.
- R10: In test mode, `dq_oe` rises TM_DLY clocks later after the column strobe falls than it does in normal mode.
- R11: `cyc_valid` is a one-clock pulse issued the clock after the sampled row strobe rises, and `cyc_code` is never 0 when it is set. After reset, `cyc_valid`, `dq_oe`, `test_mode` and `cyc_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rd_data | input | DQ_W | Read bits from the array, used in normal mode |
| cmp_bits | input | DQ_W*GRP | Compare groups from the array, one group of GRP bits per lane |
| dq_o | output | DQ_W | Data value driven to the pins |
| dq_oe | output | 1 | Output drive enable |
| cyc_code | output | 3 | Classification of the last completed cycle |
| cyc_valid | output | 1 | One-clock pulse that marks a new `cyc_code` |
| test_mode | output | 1 | Latched test-mode flag |

## Verification
The hardest case to reach from the ports is the boundary between a read-modify-write and an indeterminate write. Both look like a read until write enable falls, and only the gap between the column-strobe fall and the write-enable fall tells them apart. The stimulus places that fall one clock after the column strobe in one cycle and ten clocks after it in another, and it also checks that the output is switched off in the indeterminate case. Test-mode latency is measured as the difference between a normal read and a test-mode read made with the same pin timing.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [2:0] {
        CYC_NONE    = 3'd0,
        CYC_READ    = 3'd1,
        CYC_EWRITE  = 3'd2,
        CYC_RMW     = 3'd3,
        CYC_RASONLY = 3'd4,
        CYC_CBR     = 3'd5,
        CYC_TENTRY  = 3'd6,
        CYC_INDET   = 3'd7
    } cyc_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACTIVE,
        PH_REFRESH
    } phase_e;

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/dcc_classifier.sv
module dcc_classifier
    import dcc_pkg::*;
#(
    parameter int RMW_MIN = 5,
    parameter int TM_DLY  = 1,
    parameter int AGE_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_l,
    input  logic             cas_l,
    input  logic             we_l,
    output cyc_e             code_o,
    output logic             vld_o,
    output logic             tmode_o,
    output logic             rd_kind_o,
    output logic [AGE_W-1:0] age_o
);

    localparam int AGE_MAX = RMW_MIN + TM_DLY + 1;

    typedef struct packed {
        phase_e           phase;
        cyc_e             cls;
        logic             cas_seen;
        logic [AGE_W-1:0] age;
        logic             tmode;
        logic             ras_p;
        logic             cas_p;
        logic             we_p;
        cyc_e             code;
        logic             vld;
    } st_t;

    st_t s_d, s_q;
    logic ras_fall, ras_rise, cas_fall, we_fall;

    always_comb begin
        ras_fall = ras_l && !s_q.ras_p;
        ras_rise = !ras_l && s_q.ras_p;
        cas_fall = cas_l && !s_q.cas_p;
        we_fall  = we_l && !s_q.we_p;

        s_d       = s_q;
        s_d.vld   = 1'b0;
        s_d.ras_p = ras_l;
        s_d.cas_p = cas_l;
        s_d.we_p  = we_l;

        if (!cas_l) begin
            s_d.age = '0;
        end else if (s_q.age != AGE_W'(AGE_MAX)) begin
            s_d.age = s_q.age + 1'b1;
        end

        unique case (s_q.phase)
            PH_IDLE: begin
                if (ras_fall) begin
                    if (cas_l) begin
                        s_d.phase = PH_REFRESH;
                        s_d.cls   = we_l ? CYC_TENTRY : CYC_CBR;
                        s_d.tmode = we_l;
                    end else begin
                        s_d.phase    = PH_ACTIVE;
                        s_d.cls      = CYC_NONE;
                        s_d.cas_seen = 1'b0;
                    end
                end
            end
            PH_ACTIVE: begin
                if (ras_rise) begin
                    s_d.phase = PH_IDLE;
                    s_d.vld   = 1'b1;
                    s_d.cls   = CYC_NONE;
                    if (!s_q.cas_seen) begin
                        s_d.code  = CYC_RASONLY;
                        s_d.tmode = 1'b0;
                    end else begin
                        s_d.code = s_q.cls;
                    end
                end else begin
                    if (cas_fall && !s_q.cas_seen) begin
                        s_d.cas_seen = 1'b1;
                        s_d.cls      = we_l ? CYC_EWRITE : CYC_READ;
                    end
                    if (we_fall && s_q.cas_seen && s_q.cls == CYC_READ) begin
                        s_d.cls = (s_q.age >= AGE_W'(RMW_MIN)) ? CYC_RMW : CYC_INDET;
                    end
                end
            end
            PH_REFRESH: begin
                if (ras_rise) begin
                    s_d.phase = PH_IDLE;
                    s_d.vld   = 1'b1;
                    s_d.code  = s_q.cls;
                    s_d.cls   = CYC_NONE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cls: CYC_NONE, cas_seen: 1'b0, age: '0,
                     tmode: 1'b0, ras_p: 1'b0, cas_p: 1'b0, we_p: 1'b0,
                     code: CYC_NONE, vld: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o    = s_q.code;
    assign vld_o     = s_q.vld;
    assign tmode_o   = s_q.tmode;
    assign rd_kind_o = (s_q.phase == PH_ACTIVE) &&
                       (s_q.cls == CYC_READ || s_q.cls == CYC_RMW);
    assign age_o     = s_q.age;

endmodule

// File: rtl/dcc_dq_path.sv
module dcc_dq_path #(
    parameter int DQ_W   = 8,
    parameter int GRP    = 4,
    parameter int TM_DLY = 1,
    parameter int AGE_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_kind,
    input  logic                cas_l,
    input  logic                oe_l,
    input  logic                tmode,
    input  logic [AGE_W-1:0]    age,
    input  logic [DQ_W-1:0]     rd_data,
    input  logic [DQ_W*GRP-1:0] cmp_bits,
    output logic [DQ_W-1:0]     dq_o,
    output logic                dq_oe
);

    typedef struct packed {
        logic            oe;
        logic [DQ_W-1:0] dq;
    } out_t;

    out_t o_d, o_q;
    logic [DQ_W-1:0] lane_ok;
    logic [AGE_W-1:0] need_age;

    for (genvar g = 0; g < DQ_W; g++) begin : g_lane
        assign lane_ok[g] = (cmp_bits[g*GRP +: GRP] == {GRP{cmp_bits[g*GRP]}});
    end

    always_comb begin
        need_age = tmode ? AGE_W'(TM_DLY + 1) : AGE_W'(1);
        o_d.oe   = rd_kind && cas_l && oe_l && (age >= need_age);
        o_d.dq   = o_d.oe ? (tmode ? lane_ok : rd_data) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign dq_o  = o_q.dq;
    assign dq_oe = o_q.oe;

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcc_pkg::*;
#(
    parameter int DQ_W    = 8,
    parameter int GRP     = 4,
    parameter int SYNC_N  = 2,
    parameter int RMW_MIN = 5,
    parameter int TM_DLY  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [DQ_W-1:0]     rd_data,
    input  logic [DQ_W*GRP-1:0] cmp_bits,
    output logic [DQ_W-1:0]     dq_o,
    output logic                dq_oe,
    output logic [2:0]          cyc_code,
    output logic                cyc_valid,
    output logic                test_mode
);

    localparam int AGE_W = $clog2(RMW_MIN + TM_DLY + 2);

    logic [3:0]       strobe_s;
    logic             ras_l, cas_l, we_l, oe_l;
    logic             rd_kind;
    logic [AGE_W-1:0] cas_age;
    cyc_e             code;

    dcc_sync #(.W(4), .STAGES(SYNC_N), .RST_VAL(4'hF)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ras_n, cas_n, we_n, oe_n}),
        .dout (strobe_s)
    );

    assign ras_l = ~strobe_s[3];
    assign cas_l = ~strobe_s[2];
    assign we_l  = ~strobe_s[1];
    assign oe_l  = ~strobe_s[0];

    dcc_classifier #(.RMW_MIN(RMW_MIN), .TM_DLY(TM_DLY), .AGE_W(AGE_W)) u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_l    (ras_l),
        .cas_l    (cas_l),
        .we_l     (we_l),
        .code_o   (code),
        .vld_o    (cyc_valid),
        .tmode_o  (test_mode),
        .rd_kind_o(rd_kind),
        .age_o    (cas_age)
    );

    dcc_dq_path #(.DQ_W(DQ_W), .GRP(GRP), .TM_DLY(TM_DLY), .AGE_W(AGE_W)) u_dq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_kind (rd_kind),
        .cas_l   (cas_l),
        .oe_l    (oe_l),
        .tmode   (test_mode),
        .age     (cas_age),
        .rd_data (rd_data),
        .cmp_bits(cmp_bits),
        .dq_o    (dq_o),
        .dq_oe   (dq_oe)
    );

    assign cyc_code = code;

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ras_l,
    input logic       cas_l,
    input logic       we_l,
    input logic       oe_l,
    input logic       rd_kind,
    input logic       dq_oe,
    input logic [2:0] cyc_code,
    input logic       cyc_valid,
    input logic       test_mode
);

    p_oe_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> ($past(cas_l) && $past(oe_l)));

    p_no_drive_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(rd_kind));

    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> !cyc_valid);

    p_valid_after_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (!$past(ras_l) && $past(ras_l, 2)));

    p_code_known_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_code != 3'd0));

    p_tm_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> ($past(cas_l) && $past(we_l)));

    p_tm_entry_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_code == 3'd6) |-> test_mode);

    p_tm_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> ($past(cas_l) || !$past(ras_l)));

endmodule

bind dram_cycle_decoder dcc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_l    (ras_l),
    .cas_l    (cas_l),
    .we_l     (we_l),
    .oe_l     (oe_l),
    .rd_kind  (rd_kind),
    .dq_oe    (dq_oe),
    .cyc_code (cyc_code),
    .cyc_valid(cyc_valid),
    .test_mode(test_mode)
);

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;

    localparam int DQ_W   = 8;
    localparam int GRP    = 4;
    localparam int TM_DLY = 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [DQ_W-1:0]     rd_data = '0;
    logic [DQ_W*GRP-1:0] cmp_bits = '0;
    logic [DQ_W-1:0]     dq_o;
    logic                dq_oe;
    logic [2:0]          cyc_code;
    logic                cyc_valid;
    logic                test_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_q[$];

    always #4 clk = ~clk;

    dram_cycle_decoder #(.DQ_W(DQ_W), .GRP(GRP), .TM_DLY(TM_DLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .rd_data(rd_data), .cmp_bits(cmp_bits), .dq_o(dq_o),
        .dq_oe(dq_oe), .cyc_code(cyc_code), .cyc_valid(cyc_valid),
        .test_mode(test_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor: one expected code per reported cycle (R11 pulse)
    initial begin
        forever begin
            @(negedge clk);
            if (cyc_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected cycle report", cyc_code, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc_code == 3'(e), "R1-code cycle classification", cyc_code, e);
                end
            end
        end
    end

    // read cycle; returns cycles from column strobe fall to output on
    task automatic read_cycle(output int lat, input logic [DQ_W-1:0] exp_dq, input string req);
        exp_q.push_back(1);
        oe_n = 1'b0; ras_n = 1'b0; tick(3);
        cas_n = 1'b0;
        lat = 0;
        while (!dq_oe && lat < 20) begin tick(1); lat++; end
        chk(dq_oe == 1'b1, "R6 output on in read", dq_oe, 1);
        chk(dq_o == exp_dq, req, dq_o, exp_dq);
        oe_n = 1'b1; tick(4);
        chk(dq_oe == 1'b0, "R6 output off on OE high", dq_oe, 0);
        oe_n = 1'b0; tick(4);
        chk(dq_oe == 1'b1, "R6 output back on", dq_oe, 1);
        cas_n = 1'b1; tick(4);
        chk(dq_oe == 1'b0, "R6 output off on CAS high", dq_oe, 0);
        ras_n = 1'b1; oe_n = 1'b1; tick(6);
    endtask

    task automatic early_write();
        bit seen;
        exp_q.push_back(2);
        seen = 1'b0;
        oe_n = 1'b0; ras_n = 1'b0; we_n = 1'b0; tick(3);
        cas_n = 1'b0;
        for (int i = 0; i < 10; i++) begin tick(1); if (dq_oe) seen = 1'b1; end
        cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1;
        for (int i = 0; i < 4; i++) begin tick(1); if (dq_oe) seen = 1'b1; end
        oe_n = 1'b1;
        chk(!seen, "R5 early write keeps output off", seen, 0);
        tick(4);
    endtask

    task automatic rmw_cycle();
        exp_q.push_back(3);
        oe_n = 1'b0; ras_n = 1'b0; tick(3);
        cas_n = 1'b0; tick(6);
        chk(dq_oe == 1'b1, "R7 read data driven before write", dq_oe, 1);
        tick(4);
        oe_n = 1'b1; we_n = 1'b0; tick(4);
        cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; tick(6);
    endtask

    task automatic indet_cycle();
        exp_q.push_back(7);
        oe_n = 1'b0; ras_n = 1'b0; tick(3);
        cas_n = 1'b0; tick(1);
        we_n = 1'b0; tick(6);
        chk(dq_oe == 1'b0, "R8 indeterminate write output off", dq_oe, 0);
        cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; tick(6);
    endtask

    task automatic ras_only();
        exp_q.push_back(4);
        ras_n = 1'b0; tick(6);
        ras_n = 1'b1; tick(6);
    endtask

    task automatic cbr(input bit with_we);
        exp_q.push_back(with_we ? 6 : 5);
        cas_n = 1'b0; we_n = with_we ? 1'b0 : 1'b1; tick(3);
        ras_n = 1'b0; tick(5);
        ras_n = 1'b1; tick(3);
        cas_n = 1'b1; we_n = 1'b1; tick(6);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int lat_n, lat_t;
        logic [DQ_W-1:0] exp_lane;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk(cyc_valid == 1'b0, "R11 reset valid", cyc_valid, 0);
        chk(dq_oe == 1'b0, "R11 reset dq_oe", dq_oe, 0);
        chk(test_mode == 1'b0, "R11 reset test_mode", test_mode, 0);
        chk(cyc_code == 3'd0, "R11 reset code", cyc_code, 0);

        rd_data = 8'hA5;
        read_cycle(lat_n, 8'hA5, "R6 normal read data");
        rd_data = 8'h3C;
        read_cycle(lat_n, 8'h3C, "R6 normal read data second pattern");
        early_write();
        rmw_cycle();
        indet_cycle();
        ras_only();
        chk(test_mode == 1'b0, "R4 row-only leaves flag clear", test_mode, 0);
        cbr(1'b0);
        chk(test_mode == 1'b0, "R1 refresh does not enter test", test_mode, 0);

        // R2 entry, R9 compression, R10 latency
        cbr(1'b1);
        chk(test_mode == 1'b1, "R2 test mode latched", test_mode, 1);
        for (int l = 0; l < DQ_W; l++) begin
            case (l % 4)
                0: cmp_bits[l*GRP +: GRP] = 4'hF;
                1: cmp_bits[l*GRP +: GRP] = 4'h0;
                2: cmp_bits[l*GRP +: GRP] = 4'h8;
                default: cmp_bits[l*GRP +: GRP] = 4'h6;
            endcase
            exp_lane[l] = (l % 4) < 2;
        end
        read_cycle(lat_t, exp_lane, "R9 test-mode lane compare");
        chk(lat_t - lat_n == TM_DLY, "R10 test-mode latency", lat_t - lat_n, TM_DLY);
        chk(test_mode == 1'b1, "R3 flag held after read", test_mode, 1);
        early_write();
        chk(test_mode == 1'b1, "R3 flag held after write", test_mode, 1);
        ras_only();
        chk(test_mode == 1'b0, "R3 row-only clears flag", test_mode, 0);
        cbr(1'b1);
        chk(test_mode == 1'b1, "R2 re-entry", test_mode, 1);
        cbr(1'b0);
        chk(test_mode == 1'b0, "R3 refresh clears flag", test_mode, 0);

        tick(10);
        chk(exp_q.size() == 0, "R11 every cycle reported", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule